// File: doc/BRIEF.md
# Variable-Width CRC Message FIFO

This block holds message data that a processor writes over a 16-bit bus until a serial CRC shifter is ready to consume it. The storage is always eight 16-bit entries. How those entries are used depends on a 5-bit width setting `W`, where the element width is `W+1` bits. For narrow elements, two bytes share one entry. For medium elements, each entry holds one element. For wide elements, an element spans two entries.

The bus side has a single write strobe, an address select (low half or high half of the data register) and two byte enables. What a write does depends on the width class. In byte mode, each enabled byte pushes one element. In half mode, a low write pushes one element. In word mode, a low write is only held in a staging register, and the element is pushed by the following high write. The shifter side sees the oldest element, zero-extended and masked to the configured width, and takes it with a one-cycle pop strobe. A valid-element count and full and empty flags report occupancy. Dropping the enable empties the FIFO. The width setting should only be changed while the enable is low.

Top module: `crc_in_fifo`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, `full_o` is 0 and `pop_data_o` is 0.
- R2: Byte mode (`W` 0..7), depth 16. A write with `wr_hi_i`=0 pushes one element per set byte enable: bits 7:0 first when `wr_be_i[0]`=1, then bits 15:8 when `wr_be_i[1]`=1. Writes with `wr_hi_i`=1 are ignored.
- R3: Half mode (`W` 8..15), depth 8. Each write with `wr_hi_i`=0 pushes all 16 data bits, whatever the byte enables are. Writes with `wr_hi_i`=1 are ignored.
- R4: Word mode (`W` 16..31), depth 4. A write with `wr_hi_i`=0 only loads a 16-bit staging value and does not change the count. A write with `wr_hi_i`=1 pushes {high data, staged value}, and the staged value stays available for later high writes.
- R5: `pop_data_o` shows the oldest element. A `pop_i` pulse while the FIFO is not empty removes that element at the clock edge, and the count drops by one.
- R6: `full_o` is 1 exactly when the count equals the depth for the current mode. A write that finds no room is dropped and leaves the count and the contents unchanged. In byte mode with one slot left, a two-byte write keeps only bits 7:0.
- R7: `full_o` clears in the cycle after a pop from a full FIFO.
- R8: A pop while the FIFO is empty has no effect. While empty, `pop_data_o` reads 0.
- R9: A cycle with one accepted push and one accepted pop leaves the count unchanged.
- R10: Bits of `pop_data_o` above bit `W` are always 0.
- R11: While `en_i` is 0, the count and both pointers go to 0, the staging value is cleared, and writes and pops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable; low flushes the FIFO |
| width_cfg_i | input | 5 | Width setting W; element width is W+1 |
| wr_en_i | input | 1 | Bus data write strobe |
| wr_hi_i | input | 1 | Address select: 0 low half, 1 high half |
| wr_be_i | input | 2 | Byte enables for the write |
| wr_data_i | input | 16 | Bus write data |
| pop_i | input | 1 | Remove the oldest element |
| pop_data_o | output | 32 | Oldest element, masked to W+1 bits |
| count_o | output | 5 | Number of valid elements |
| full_o | output | 1 | Count equals depth for current mode |
| empty_o | output | 1 | Count is zero |

## Verification
The bench drives each width class and keeps its own queue of expected elements. It aims at these cases:
- A one-slot byte-mode write with both enables set. A design that overfills here would report a count of 17 or overwrite the oldest byte.
- Writes while full. If these leak in, later pops would return the wrong elements.
- High writes in word mode with no new low half. A design that clears the staged half after each push would return a zero low half.
- A pop at empty. If this moves the read pointer, the next element written would be lost.
- Re-enabling after a flush. A design that keeps the stale staged half would return it here instead of zero.
- Narrow widths. These expose a design that fails to mask the upper bits of `pop_data_o`.

// File: rtl/crc_fifo_pkg.sv
package crc_fifo_pkg;
  localparam int BUS_W  = 16;
  localparam int ELEM_W = 32;
  localparam int CFG_W  = 5;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'd0,
    MODE_HALF = 2'd1,
    MODE_WORD = 2'd2
  } width_mode_e;

  function automatic width_mode_e mode_of(input logic [CFG_W-1:0] w);
    if (w < CFG_W'(8))       return MODE_BYTE;
    else if (w < CFG_W'(16)) return MODE_HALF;
    return MODE_WORD;
  endfunction
endpackage

// File: rtl/crc_fifo_ctrl.sv
module crc_fifo_ctrl
  import crc_fifo_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOTS  = 2 * ENTRIES,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  width_mode_e      mode_i,
  input  logic             wr_en_i,
  input  logic             wr_hi_i,
  input  logic [1:0]       wr_be_i,
  input  logic             pop_i,
  output logic             push_a_o,
  output logic             push_b_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] count_q, depth, room, n_push;
  logic [PTR_W-1:0] wptr_q, rptr_q, ptr_mask;
  logic             lo_wr, hi_wr, pop_ok, req_a, req_b;

  always_comb begin
    case (mode_i)
      MODE_BYTE: depth = CNT_W'(SLOTS);
      MODE_HALF: depth = CNT_W'(ENTRIES);
      default:   depth = CNT_W'(ENTRIES / 2);
    endcase
    room     = depth - count_q;
    ptr_mask = PTR_W'(depth - CNT_W'(1));
    lo_wr    = en_i && wr_en_i && !wr_hi_i;
    hi_wr    = en_i && wr_en_i && wr_hi_i;
    req_a    = 1'b0;
    req_b    = 1'b0;
    case (mode_i)
      MODE_BYTE: begin
        req_a = lo_wr && wr_be_i[0];
        req_b = lo_wr && wr_be_i[1];
      end
      MODE_HALF: req_a = lo_wr;
      default:   req_a = hi_wr;
    endcase
    push_a_o = req_a && (room != '0);
    // second byte lane needs a slot beyond the one the first lane took
    push_b_o = req_b && (room > CNT_W'(req_a));
    n_push   = CNT_W'(push_a_o) + CNT_W'(push_b_o);
    pop_ok   = en_i && pop_i && (count_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else if (!en_i) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      count_q <= count_q + n_push - CNT_W'(pop_ok);
      wptr_q  <= (wptr_q + PTR_W'(n_push)) & ptr_mask;
      rptr_q  <= (rptr_q + PTR_W'(pop_ok)) & ptr_mask;
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = count_q;
  assign full_o  = (count_q == depth);
  assign empty_o = (count_q == '0);

  // R6
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && full_o && wr_en_i && !pop_i |=> $stable(count_q));
  // R7
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && full_o && pop_i && !push_a_o && !push_b_o |=> !full_o);
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && empty_o && pop_i && !wr_en_i |=> empty_o && $stable(rptr_q));
  // R9
  push_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pop_i && !empty_o && (push_a_o ^ push_b_o) |=> $stable(count_q));
  // R11
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_q == '0) && (wptr_q == '0) && (rptr_q == '0));
  // R2
  byte_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_BYTE && wr_en_i && !wr_hi_i && wr_be_i == 2'b11
      && room >= CNT_W'(2) && !pop_i |=> count_q == $past(count_q) + CNT_W'(2));
endmodule

// File: rtl/crc_fifo_store.sv
module crc_fifo_store
  import crc_fifo_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOTS  = 2 * ENTRIES,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int IDX_W  = PTR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  width_mode_e       mode_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              push_a_i,
  input  logic              push_b_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic [PTR_W-1:0]  rptr_i,
  output logic [ELEM_W-1:0] head_o
);
  logic [1:0][7:0]          mem_q [ENTRIES];
  logic [7:0]               wd_b  [ENTRIES][2];
  logic                     we_b  [ENTRIES][2];
  logic [BUS_W-1:0]         hold_q;
  logic [PTR_W-1:0]         slot_a, slot_b;
  logic [IDX_W-1:0]         idx_lo;
  logic [ENTRIES*BUS_W-1:0] flat;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      for (int l = 0; l < 2; l++) begin
        we_b[e][l] = 1'b0;
        wd_b[e][l] = wr_data_i[l*8 +: 8];
      end
    end
    slot_a = wptr_i;
    slot_b = wptr_i + PTR_W'(push_a_i);
    idx_lo = '0;
    case (mode_i)
      MODE_BYTE: begin
        if (push_a_i) begin
          we_b[slot_a[PTR_W-1:1]][slot_a[0]] = 1'b1;
          wd_b[slot_a[PTR_W-1:1]][slot_a[0]] = wr_data_i[7:0];
        end
        if (push_b_i) begin
          we_b[slot_b[PTR_W-1:1]][slot_b[0]] = 1'b1;
          wd_b[slot_b[PTR_W-1:1]][slot_b[0]] = wr_data_i[15:8];
        end
      end
      MODE_HALF: begin
        idx_lo = wptr_i[IDX_W-1:0];
        if (push_a_i) begin
          we_b[idx_lo][0] = 1'b1;
          we_b[idx_lo][1] = 1'b1;
        end
      end
      default: begin
        // element spans an even/odd entry pair: staged half low, bus data high
        idx_lo = {wptr_i[IDX_W-2:0], 1'b0};
        if (push_a_i) begin
          we_b[idx_lo][0]        = 1'b1;
          we_b[idx_lo][1]        = 1'b1;
          wd_b[idx_lo][0]        = hold_q[7:0];
          wd_b[idx_lo][1]        = hold_q[15:8];
          we_b[idx_lo | 'd1][0]  = 1'b1;
          we_b[idx_lo | 'd1][1]  = 1'b1;
        end
      end
    endcase
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    for (genvar l = 0; l < 2; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         mem_q[e][l] <= '0;
        else if (we_b[e][l]) mem_q[e][l] <= wd_b[e][l];
      end
    end
    assign flat[e*BUS_W +: BUS_W] = mem_q[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (!en_i)  hold_q <= '0;
    else if (wr_en_i && !wr_hi_i && mode_i == MODE_WORD) hold_q <= wr_data_i;
  end

  always_comb begin
    case (mode_i)
      MODE_BYTE: head_o = {24'd0, flat[{rptr_i, 3'b000} +: 8]};
      MODE_HALF: head_o = {16'd0, flat[{rptr_i[IDX_W-1:0], 4'b0000} +: 16]};
      default:   head_o = flat[{rptr_i[IDX_W-2:0], 5'b00000} +: 32];
    endcase
  end

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_WORD && wr_en_i && !wr_hi_i |=> hold_q == $past(wr_data_i));
  // R11
  hold_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> hold_q == '0);
endmodule

// File: rtl/crc_in_fifo.sv
module crc_in_fifo
  import crc_fifo_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int PTR_W  = $clog2(2 * ENTRIES),
  localparam int CNT_W  = $clog2(2 * ENTRIES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CFG_W-1:0]  width_cfg_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [1:0]        wr_be_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              pop_i,
  output logic [ELEM_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o
);
  width_mode_e       mode;
  logic              push_a, push_b;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [ELEM_W-1:0] head, elem_mask;

  assign mode      = mode_of(width_cfg_i);
  assign elem_mask = {ELEM_W{1'b1}} >> (CFG_W'(ELEM_W - 1) - width_cfg_i);

  crc_fifo_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk_i, .rst_ni, .en_i,
    .mode_i   (mode),
    .wr_en_i, .wr_hi_i, .wr_be_i, .pop_i,
    .push_a_o (push_a),
    .push_b_o (push_b),
    .wptr_o   (wptr),
    .rptr_o   (rptr),
    .count_o, .full_o, .empty_o
  );

  crc_fifo_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni, .en_i,
    .mode_i   (mode),
    .wr_en_i, .wr_hi_i, .wr_data_i,
    .push_a_i (push_a),
    .push_b_i (push_b),
    .wptr_i   (wptr),
    .rptr_i   (rptr),
    .head_o   (head)
  );

  assign pop_data_o = empty_o ? '0 : (head & elem_mask);
endmodule

// File: tb/tb_crc_in_fifo.sv
module tb_crc_in_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, en, wr_en, wr_hi, pop;
  logic [4:0]  wcfg;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [31:0] pop_data;
  logic [4:0]  count;
  logic        full, empty;

  int          n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  logic [15:0] m_hold;
  string       cur_req = "R5";

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_in_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .width_cfg_i(wcfg),
    .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_be_i(be), .wr_data_i(wdata),
    .pop_i(pop), .pop_data_o(pop_data), .count_o(count),
    .full_o(full), .empty_o(empty)
  );

  function automatic int depth_of(input logic [4:0] w);
    return (w < 8) ? 16 : (w < 16) ? 8 : 4;
  endfunction

  function automatic logic [31:0] mask_of(input logic [4:0] w);
    return 32'hFFFF_FFFF >> (5'd31 - w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic state(input string req);
    chk(req, 32'(count), 32'(exp_q.size()));
    chk(req, 32'(full),  32'(exp_q.size() == depth_of(wcfg)));
    chk(req, 32'(empty), 32'(exp_q.size() == 0));
  endtask

  // driver: models acceptance and queues expected elements
  task automatic wr(input logic hi, input logic [1:0] b, input logic [15:0] d,
                    input logic do_pop = 1'b0);
    int room;
    room  = depth_of(wcfg) - exp_q.size();
    wr_en = 1'b1; wr_hi = hi; be = b; wdata = d; pop = do_pop;
    if (wcfg < 8) begin
      if (!hi) begin
        if (b[0] && room > 0) begin exp_q.push_back(32'(d[7:0]) & mask_of(wcfg)); room--; end
        if (b[1] && room > 0) exp_q.push_back(32'(d[15:8]) & mask_of(wcfg));
      end
    end else if (wcfg < 16) begin
      if (!hi && room > 0) exp_q.push_back(32'(d) & mask_of(wcfg));
    end else begin
      if (!hi) m_hold = d;
      else if (room > 0) exp_q.push_back({d, m_hold} & mask_of(wcfg));
    end
    tick();
    wr_en = 1'b0; pop = 1'b0;
  endtask

  task automatic pop_one();
    pop = 1'b1; tick(); pop = 1'b0;
  endtask

  task automatic reconf(input logic [4:0] w);
    en = 1'b0; wcfg = w; tick();
    exp_q.delete(); m_hold = '0; en = 1'b1;
  endtask

  task automatic drain(input string req);
    cur_req = req;
    while (exp_q.size() > 0) pop_one();
    state(req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // monitor: compare the head against the scoreboard on every accepted pop
  always @(negedge clk) begin
    if (rst_n && en && pop && exp_q.size() > 0) begin
      chk(cur_req, pop_data, exp_q[0]);
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_hi = 1'b0; pop = 1'b0;
    be = 2'b00; wdata = '0; wcfg = 5'd7; m_hold = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    chk("R1", 32'(count), 0); chk("R1", 32'(empty), 1);
    chk("R1", 32'(full), 0);  chk("R1", pop_data, 0);

    // R2 byte lanes, high address ignored
    reconf(5'd7);
    wr(1'b0, 2'b01, 16'h77A5);
    wr(1'b0, 2'b10, 16'h3C11);
    wr(1'b0, 2'b11, 16'h2211);
    wr(1'b1, 2'b11, 16'hFFFF);
    state("R2");
    chk("R5", pop_data, 32'h0000_00A5);
    drain("R5");

    // R6 fill byte mode, last slot takes low lane only, then drop
    for (int i = 0; i < 15; i++) wr(1'b0, 2'b01, 16'(i + 1));
    state("R6");
    wr(1'b0, 2'b11, 16'hBBAA);
    state("R6");
    wr(1'b0, 2'b01, 16'h00EE);
    state("R6");
    // R7 full clears after one pop
    cur_req = "R7";
    pop_one();
    chk("R7", 32'(full), 0);
    chk("R7", 32'(count), 15);
    drain("R6");

    // R10 upper bits masked
    reconf(5'd5);
    wr(1'b0, 2'b01, 16'h00FF);
    chk("R10", pop_data, 32'h0000_003F);
    drain("R10");

    // R3 half mode
    reconf(5'd11);
    wr(1'b0, 2'b01, 16'hABCD);
    wr(1'b1, 2'b11, 16'h1234);
    state("R3");
    chk("R3", pop_data, 32'h0000_0BCD);
    for (int i = 0; i < 7; i++) wr(1'b0, 2'b11, 16'(16'h0111 * (i + 1)));
    state("R3");
    wr(1'b0, 2'b11, 16'h0FFF);
    state("R6");
    drain("R3");

    // R4 word mode with staged low half
    reconf(5'd31);
    wr(1'b0, 2'b11, 16'h1111);
    state("R4");
    wr(1'b1, 2'b11, 16'h2222);
    wr(1'b1, 2'b11, 16'h3333);
    chk("R4", pop_data, 32'h2222_1111);
    wr(1'b0, 2'b11, 16'h4444); wr(1'b1, 2'b11, 16'h5555);
    wr(1'b0, 2'b11, 16'h6666); wr(1'b1, 2'b11, 16'h7777);
    state("R6");
    wr(1'b0, 2'b11, 16'h9999); wr(1'b1, 2'b11, 16'h8888);
    state("R6");
    drain("R4");

    // R10 odd wide width
    reconf(5'd23);
    wr(1'b0, 2'b11, 16'hABCD); wr(1'b1, 2'b11, 16'hFF12);
    chk("R10", pop_data, 32'h0012_ABCD);
    drain("R10");

    // R8 pop at empty does nothing
    pop_one();
    state("R8");
    chk("R8", pop_data, 32'h0);
    wr(1'b0, 2'b11, 16'h0001); wr(1'b1, 2'b11, 16'h0002);
    chk("R8", pop_data, 32'h0002_0001);
    drain("R8");

    // R9 simultaneous push and pop
    reconf(5'd15);
    wr(1'b0, 2'b11, 16'hA0A0);
    wr(1'b0, 2'b11, 16'hB1B1);
    cur_req = "R9";
    wr(1'b0, 2'b11, 16'hC2C2, 1'b1);
    state("R9");
    drain("R9");

    // R11 disable flushes count and staged half
    reconf(5'd31);
    wr(1'b0, 2'b11, 16'h1234); wr(1'b1, 2'b11, 16'h5678);
    wr(1'b0, 2'b11, 16'h9ABC);
    en = 1'b0; wr_en = 1'b1; wr_hi = 1'b1; wdata = 16'hFFFF; pop = 1'b1;
    tick();
    wr_en = 1'b0; pop = 1'b0;
    exp_q.delete(); m_hold = '0;
    state("R11");
    en = 1'b1;
    wr(1'b1, 2'b11, 16'h4321);
    chk("R11", pop_data, 32'h4321_0000);
    drain("R11");

    summary();
  end
endmodule